// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of an SDRAM bus and samples them on every rising clock edge. From chip select, the three command strobes, the clock enable, the bank address and address bit 10, it works out which single command the edge carried. It also keeps a small state machine for each bank. A bank is in one of four states: closed (idle), open with a row held, in a read burst, or in a write burst.

Every command is judged against the state of the bank it names, or against all banks when it is a refresh, mode-set or power-down command. A command that is not allowed raises a one-cycle illegal strobe and leaves every bank as it was. A flag reports when every bank is closed, which is the condition a controller waits for before refresh or a mode change. The block is meant as a passive monitor beside a memory controller, or as the command front end of a memory model.

The decoded command, the illegal strobe and the bank states are registered. They describe the edge just sampled and are valid from that edge until the next one.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While reset is asserted and after it is released, every bank reads idle (code 0), `all_idle` is 1, `illegal` is 0 and `cmd_oh` holds only the no-operation bit.
- R2: `cmd_oh` is one-hot, with bit 0 deselect, 1 no-operation, 2 activate, 3 read, 4 write, 5 precharge, 6 auto-refresh, 7 self-refresh entry, 8 mode set, 9 burst stop and 10 power-down entry. Chip select high decodes as deselect. With chip select low, {ras_n,cas_n,we_n} = 011 is activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop and 111 no-operation.
- R3: An activate to an idle bank opens it (code 1). An activate to a bank that is open or bursting is illegal.
- R4: A read or write to an open or bursting bank puts it in read (code 2) or write (code 3) for BURST_LEN edges, counting the issuing edge. It then returns to open, or to idle if `a10` was high on the command.
- R5: A read, write or burst stop aimed at an idle bank is illegal.
- R6: A precharge with `a10` low closes only the bank on `ba`, and this ends that bank's burst. Bursts in other banks keep running. A precharge to an idle bank is legal and changes nothing.
- R7: A precharge with `a10` high closes every bank.
- R8: Refresh (an edge where `cke` was high before and is high now), self-refresh entry (the refresh encoding with `cke` going from high to low), power-down entry (no-operation or deselect with `cke` going from high to low) and mode set are illegal unless every bank is idle.
- R9: `illegal` is high for exactly the cycle after an edge with an illegal command, and that command changes no bank state.
- R10: A read or write to one bank ends any burst running in another bank. A burst stop ends every running burst. A bank whose burst ends this way goes to open, or to idle if its burst carried auto-precharge.
- R11: On an edge where the previous sample of `cke` was low, the clock is suspended. The command decodes as no-operation, and bank states and burst counts hold.
- R12: `all_idle` is 1 exactly when every bank state is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| cmd_oh | output | 11 | One-hot decoded command of the last edge |
| bank_state | output | 2*NUM_BANKS (8) | Bank n state in bits [2n+1:2n] |
| illegal | output | 1 | Last edge carried an illegal command |
| all_idle | output | 1 | Every bank is idle |

## Verification
A table of command vectors first walks the legal paths. It opens banks, runs read and write bursts with and without auto-precharge, and closes banks one at a time and all together. Between these it places commands that must be refused: a second activate, a read or burst stop to a closed bank, and refresh or mode set while a bank is open. This separates the per-bank legality test from the all-banks test. Other sequences interleave bursts across banks. These show whether a new column command, a burst stop or a precharge ends the right burst and leaves the others running. Directed sequences then hold `cke` low in the middle of a burst, so that a burst which failed to freeze would end early. They also enter self-refresh and power-down from the all-idle state and apply reset in the middle of a run.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_st_e;

  localparam int CMD_W   = 11;
  localparam int C_DESEL = 0;
  localparam int C_NOP   = 1;
  localparam int C_ACT   = 2;
  localparam int C_RD    = 3;
  localparam int C_WR    = 4;
  localparam int C_PRE   = 5;
  localparam int C_REF   = 6;
  localparam int C_SREF  = 7;
  localparam int C_MRS   = 8;
  localparam int C_BST   = 9;
  localparam int C_PDN   = 10;

  typedef logic [CMD_W-1:0] cmd_vec_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  input  logic     cke,
  input  logic     cke_prev,
  output cmd_vec_t cmd
);

  always_comb begin
    cmd = '0;
    if (!cke_prev) begin
      cmd[C_NOP] = 1'b1;                 // suspended edge
    end else if (cs_n) begin
      if (cke) cmd[C_DESEL] = 1'b1;
      else     cmd[C_PDN]   = 1'b1;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011: cmd[C_ACT] = 1'b1;
        3'b101: cmd[C_RD]  = 1'b1;
        3'b100: cmd[C_WR]  = 1'b1;
        3'b010: cmd[C_PRE] = 1'b1;
        3'b001: begin
          if (cke) cmd[C_REF]  = 1'b1;
          else     cmd[C_SREF] = 1'b1;
        end
        3'b000: cmd[C_MRS] = 1'b1;
        3'b110: cmd[C_BST] = 1'b1;
        3'b111: begin
          if (cke) cmd[C_NOP] = 1'b1;
          else     cmd[C_PDN] = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,      // clock not suspended this edge
  input  logic     sel,      // bank address names this bank
  input  logic     a10,
  input  logic     do_act,   // legal commands only
  input  logic     do_pre,
  input  logic     do_rd,
  input  logic     do_wr,
  input  logic     do_bst,
  output bank_st_e state
);

  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  bank_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ap_q, ap_d;
  logic             bursting;
  bank_st_e         burst_end;

  assign bursting  = (state_q == BK_RD) || (state_q == BK_WR);
  assign burst_end = ap_q ? BK_IDLE : BK_OPEN;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ap_d    = ap_q;
    if (bursting) begin
      if (cnt_q == '0) state_d = burst_end;
      else             cnt_d   = cnt_q - 1'b1;
    end
    if (do_act && sel) state_d = BK_OPEN;
    if (do_pre && (sel || a10)) begin
      state_d = BK_IDLE;
      ap_d    = 1'b0;
    end
    if (do_rd || do_wr) begin
      if (sel) begin
        state_d = do_rd ? BK_RD : BK_WR;
        cnt_d   = CNT_LOAD;
        ap_d    = a10;
      end else if (bursting) begin
        state_d = burst_end;
      end
    end
    if (do_bst && bursting) state_d = burst_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      ap_q    <= 1'b0;
    end else if (run) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ap_q    <= ap_d;
    end
  end

  assign state = state_q;

  // R5: an idle bank never jumps straight into a burst
  p_no_burst_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BK_IDLE) |=> !((state_q == BK_RD) || (state_q == BK_WR)));

  // R11: a suspended edge leaves the bank untouched
  p_suspend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   cke,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  output logic [CMD_W-1:0]       cmd_oh,
  output logic [2*NUM_BANKS-1:0] bank_state,
  output logic                   illegal,
  output logic                   all_idle
);

  logic     cke_prev_q;
  cmd_vec_t dec_cmd, cmd_q;
  logic     illegal_q, legal;
  bank_st_e st [NUM_BANKS];
  bank_st_e sel_st;
  logic     idle_all_w;

  sdram_cmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .cke_prev (cke_prev_q),
    .cmd      (dec_cmd)
  );

  always_comb begin
    idle_all_w = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++)
      if (st[i] != BK_IDLE) idle_all_w = 1'b0;
  end

  assign sel_st = st[ba];

  always_comb begin
    legal = 1'b1;
    if (dec_cmd[C_ACT])
      legal = (sel_st == BK_IDLE);
    if (dec_cmd[C_RD] || dec_cmd[C_WR] || dec_cmd[C_BST])
      legal = (sel_st != BK_IDLE);
    if (dec_cmd[C_REF] || dec_cmd[C_SREF] || dec_cmd[C_MRS] || dec_cmd[C_PDN])
      legal = idle_all_w;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_fsm #(.BURST_LEN(BURST_LEN)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (cke_prev_q),
      .sel    (ba == BA_W'(g)),
      .a10    (a10),
      .do_act (legal && dec_cmd[C_ACT]),
      .do_pre (legal && dec_cmd[C_PRE]),
      .do_rd  (legal && dec_cmd[C_RD]),
      .do_wr  (legal && dec_cmd[C_WR]),
      .do_bst (legal && dec_cmd[C_BST]),
      .state  (st[g])
    );
    assign bank_state[2*g +: 2] = st[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b1;
      cmd_q      <= cmd_vec_t'(1 << C_NOP);
      illegal_q  <= 1'b0;
    end else begin
      cke_prev_q <= cke;
      cmd_q      <= dec_cmd;
      illegal_q  <= !legal;
    end
  end

  assign cmd_oh   = cmd_q;
  assign illegal  = illegal_q;
  assign all_idle = idle_all_w;

  // R2: exactly one command per edge
  p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_q) == 1);

  // R7: precharge-all on a running edge leaves every bank closed
  p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_prev_q && dec_cmd[C_PRE] && a10) |=> all_idle);

  // R8: accepted refresh, mode set or power-down only from all-idle
  p_idle_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q[C_REF] || cmd_q[C_SREF] || cmd_q[C_MRS] || cmd_q[C_PDN]) && !illegal_q)
      |-> $past(all_idle));

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/100ps
module sdram_cmd_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke, a10;
  logic [1:0]  ba;
  logic [10:0] cmd_oh;
  logic [7:0]  bank_state;
  logic        illegal, all_idle;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_oh(cmd_oh),
    .bank_state(bank_state), .illegal(illegal), .all_idle(all_idle)
  );

  // {cs_n,ras_n,cas_n,we_n}
  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD  = 4'b0101,
                         K_WR  = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000, K_BST = 4'b0110, K_DES = 4'b1111;

  // {pins4, cke, ba2, a10, req4, exp_cmd_idx4, exp_illegal, exp_state8}
  localparam int NV = 36;
  localparam logic [24:0] TBL [NV] = '{
    {K_NOP,1'b1,2'd0,1'b0,4'd2, 4'd1, 1'b0,8'h00},
    {K_ACT,1'b1,2'd0,1'b0,4'd3, 4'd2, 1'b0,8'h01},  // R3 open bank 0
    {K_ACT,1'b1,2'd0,1'b0,4'd3, 4'd2, 1'b1,8'h01},  // R3 second activate
    {K_RD ,1'b1,2'd1,1'b0,4'd5, 4'd3, 1'b1,8'h01},  // R5 read idle bank
    {K_ACT,1'b1,2'd1,1'b0,4'd3, 4'd2, 1'b0,8'h05},
    {K_WR ,1'b1,2'd0,1'b0,4'd4, 4'd4, 1'b0,8'h07},  // R4 write burst
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h07},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h07},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h07},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h05},  // R4 back to open
    {K_RD ,1'b1,2'd1,1'b1,4'd4, 4'd3, 1'b0,8'h09},  // R4 read auto-precharge
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h09},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h09},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h09},
    {K_NOP,1'b1,2'd0,1'b0,4'd4, 4'd1, 1'b0,8'h01},  // R4 closes itself
    {K_PRE,1'b1,2'd2,1'b0,4'd6, 4'd5, 1'b0,8'h01},  // R6 precharge idle bank
    {K_REF,1'b1,2'd0,1'b0,4'd8, 4'd6, 1'b1,8'h01},  // R8 refresh with open bank
    {K_MRS,1'b1,2'd0,1'b0,4'd8, 4'd8, 1'b1,8'h01},  // R8 mode set refused
    {K_BST,1'b1,2'd1,1'b0,4'd5, 4'd9, 1'b1,8'h01},  // R5 stop to idle bank
    {K_ACT,1'b1,2'd3,1'b0,4'd9, 4'd2, 1'b0,8'h41},  // R9 strobe drops
    {K_RD ,1'b1,2'd0,1'b0,4'd4, 4'd3, 1'b0,8'h42},
    {K_WR ,1'b1,2'd3,1'b1,4'd10,4'd4, 1'b0,8'hC1},  // R10 cross-bank interrupt
    {K_PRE,1'b1,2'd0,1'b0,4'd6, 4'd5, 1'b0,8'hC0},  // R6 other burst continues
    {K_NOP,1'b1,2'd0,1'b0,4'd6, 4'd1, 1'b0,8'hC0},
    {K_NOP,1'b1,2'd0,1'b0,4'd6, 4'd1, 1'b0,8'hC0},
    {K_NOP,1'b1,2'd0,1'b0,4'd12,4'd1, 1'b0,8'h00},  // R12 all idle again
    {K_ACT,1'b1,2'd2,1'b0,4'd3, 4'd2, 1'b0,8'h10},
    {K_RD ,1'b1,2'd2,1'b0,4'd4, 4'd3, 1'b0,8'h20},
    {K_PRE,1'b1,2'd2,1'b0,4'd6, 4'd5, 1'b0,8'h00},  // R6 precharge ends burst
    {K_ACT,1'b1,2'd1,1'b0,4'd3, 4'd2, 1'b0,8'h04},
    {K_WR ,1'b1,2'd1,1'b0,4'd4, 4'd4, 1'b0,8'h0C},
    {K_BST,1'b1,2'd1,1'b0,4'd10,4'd9, 1'b0,8'h04},  // R10 burst stop
    {K_PRE,1'b1,2'd0,1'b1,4'd7, 4'd5, 1'b0,8'h00},  // R7 precharge all
    {K_REF,1'b1,2'd0,1'b0,4'd8, 4'd6, 1'b0,8'h00},  // R8 refresh accepted
    {K_MRS,1'b1,2'd0,1'b0,4'd8, 4'd8, 1'b0,8'h00},
    {K_DES,1'b1,2'd0,1'b0,4'd2, 4'd0, 1'b0,8'h00}   // R2 deselect
  };

  task automatic check(input int req, input int exp_idx, input logic exp_ill,
                       input logic [7:0] exp_st);
    logic [10:0] exp_cmd;
    logic        exp_idle;
    exp_cmd  = 11'(1) << exp_idx;
    exp_idle = (exp_st == 8'h00);
    n_chk++;
    if (cmd_oh !== exp_cmd || illegal !== exp_ill || bank_state !== exp_st ||
        all_idle !== exp_idle) begin
      n_fail++;
      $display("FAIL R%0d: cmd=%b exp %b ill=%b exp %b st=%h exp %h idle=%b exp %b",
               req, cmd_oh, exp_cmd, illegal, exp_ill, bank_state, exp_st,
               all_idle, exp_idle);
    end
  endtask

  task automatic drive(input logic [3:0] pins, input logic ck, input logic [1:0] b,
                       input logic a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = pins;
    cke = ck; ba = b; a10 = a;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = K_NOP;
    cke = 1'b1; ba = 2'd0; a10 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1, 1, 1'b0, 8'h00);                     // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(1, 1, 1'b0, 8'h00);                     // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][24:21], TBL[i][20], TBL[i][19:18], TBL[i][17]);
      check(int'(TBL[i][16:13]), int'(TBL[i][12:9]), TBL[i][8], TBL[i][7:0]);
    end

    // R11 suspend in the middle of a read burst
    drive(K_ACT, 1'b1, 2'd0, 1'b0); check(3, 2, 1'b0, 8'h01);
    drive(K_RD , 1'b1, 2'd0, 1'b0); check(4, 3, 1'b0, 8'h02);
    drive(K_NOP, 1'b0, 2'd0, 1'b0); check(8, 10, 1'b1, 8'h02);  // R8 power-down refused
    drive(K_NOP, 1'b0, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);
    drive(K_NOP, 1'b0, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);
    drive(K_ACT, 1'b0, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);  // R11 command ignored
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h02);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h01);  // R11 burst ends late

    // R1 reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    #1 check(1, 1, 1'b0, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R8 self-refresh and power-down from all idle
    drive(K_REF, 1'b0, 2'd0, 1'b0); check(8, 7, 1'b0, 8'h00);
    drive(K_NOP, 1'b0, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h00);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h00);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(2, 1, 1'b0, 8'h00);
    drive(K_DES, 1'b0, 2'd0, 1'b0); check(8, 10, 1'b0, 8'h00);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(11, 1, 1'b0, 8'h00);
    drive(K_NOP, 1'b1, 2'd0, 1'b0); check(2, 1, 1'b0, 8'h00);

    finish_run();
  end

endmodule